// File: doc/BRIEF.md
# Multi-Port Atomic Lock Unit

This block holds a small bank of lock words that several processor ports share. Each port can ask for one of four operations on a chosen word: an atomic test-and-set, an atomic exchange with a value the port supplies, a release, or a plain read of the word. The unit accepts exactly one operation per clock cycle. The chosen operation reads and updates its word in that single cycle, so no other port can slip a change in between the read and the write.

Each port has a valid/ready request handshake. When several ports ask in the same cycle, a rotating-priority arbiter picks one of them. The other ports keep their requests asserted until they are granted. The granted port gets its answer, the success bit or the old word, in the cycle after the grant. Software builds spin locks from the test-and-set answer. It uses the exchange operation to store or swap whole values.

Top module: `lockunit_top`

## Requirements
- R1: After reset every lock word reads 0 and no response is asserted while reset is held.
- R2: Test-and-set (op code 0) on a word that holds 0 stores 1 in it and returns 1.
- R3: Test-and-set on a word holding any non-zero value leaves the word unchanged and returns 0.
- R4: Exchange (op code 1) stores the port's write value in the word and returns the value the word held before.
- R5: Release (op code 2) stores 0 in the word and returns the value it held before.
- R6: Read (op code 3) returns the word's value and does not change it.
- R7: At most one port sees ready in a cycle, and ready is only raised for a port whose valid is high.
- R8: Priority rotates. After port p is granted, the search for the next grant starts at port p+1 (wrapping), so a port that was just granted loses to any other requester.
- R9: The response is raised on the granted port only, for exactly one cycle, in the cycle that follows the handshake.
- R10: Operations on one word are applied in grant order. When several ports test-and-set the same free word in one cycle, only the first granted port receives 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | NPORT (4) | Request valid, one bit per port |
| req_ready | output | NPORT (4) | Grant for the current cycle, one bit per port |
| req_op | input | 2*NPORT (8) | Operation code per port (0 test-and-set, 1 exchange, 2 release, 3 read) |
| req_idx | input | NPORT*LW (12) | Lock word index per port |
| req_wdata | input | NPORT*DW (32) | Exchange value per port |
| rsp_valid | output | NPORT (4) | Response strobe per port |
| rsp_data | output | NPORT*DW (32) | Result per port: success bit or previous word value |

## Verification
The two functions that can meet in one cycle are arbitration among ports and the read-modify-write of one shared word. The bench raises test-and-set on the same free word from all four ports in a single cycle, holds each request until it is granted, and checks the grant sequence against the rotating-priority rule. It also checks that exactly one port receives success and that every later port receives 0. Each response is matched against a scoreboard entry that carries the expected port, data and cycle. The word is then read back to confirm it holds 1.

// File: rtl/lockunit_pkg.sv
package lockunit_pkg;

    typedef enum logic [1:0] {
        OP_TAS  = 2'd0,
        OP_XCHG = 2'd1,
        OP_FREE = 2'd2,
        OP_PEEK = 2'd3
    } lk_op_e;

endpackage

// File: rtl/lockunit_rr_arb.sv
module lockunit_rr_arb #(
    parameter int N  = 4,
    parameter int PW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    output logic [N-1:0]  gnt,
    output logic [PW-1:0] gnt_idx,
    output logic          gnt_any
);

    typedef struct packed {
        logic [PW-1:0] ptr;
    } arb_st_t;

    arb_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        gnt     = '0;
        gnt_idx = '0;
        gnt_any = 1'b0;
        // Descending offsets: the smallest offset from the pointer wins.
        for (int off = N - 1; off >= 0; off--) begin
            if (req[(int'(st_q.ptr) + off) % N]) begin
                gnt_idx = PW'((int'(st_q.ptr) + off) % N);
                gnt_any = 1'b1;
            end
        end
        if (gnt_any) begin
            gnt[gnt_idx] = 1'b1;
            st_d.ptr     = (int'(gnt_idx) == N - 1) ? '0 : gnt_idx + PW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R7: a single grant, and only to a requester
    assert_single_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));
    assert_grant_needs_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~req) == '0);
    // R8: the port granted last cycle never wins while another port competes
    assert_rotate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(gnt_any) && ($countones(req) > 1)) |-> (gnt_idx != $past(gnt_idx)));

endmodule

// File: rtl/lockunit_store.sv
module lockunit_store
    import lockunit_pkg::*;
#(
    parameter int NLOCK = 8,
    parameter int DW    = 8,
    parameter int LW    = (NLOCK > 1) ? $clog2(NLOCK) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  lk_op_e        op,
    input  logic [LW-1:0] idx,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] result
);

    typedef struct packed {
        logic [NLOCK-1:0][DW-1:0] mem;
    } st_t;

    st_t st_d, st_q;
    logic [DW-1:0] cur;

    always_comb begin
        st_d   = st_q;
        cur    = st_q.mem[idx];
        result = cur;
        if (en) begin
            unique case (op)
                OP_TAS: begin
                    if (cur == '0) begin
                        st_d.mem[idx] = DW'(1);
                        result        = DW'(1);
                    end else begin
                        result        = '0;
                    end
                end
                OP_XCHG: st_d.mem[idx] = wdata;
                OP_FREE: st_d.mem[idx] = '0;
                OP_PEEK: ;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_tas_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op == OP_TAS && st_q.mem[idx] == '0) |=> (st_q.mem[$past(idx)] == DW'(1)));
    assert_tas_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op == OP_TAS && st_q.mem[idx] != '0) |=> (st_q.mem == $past(st_q.mem)));
    assert_xchg_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op == OP_XCHG) |=> (st_q.mem[$past(idx)] == $past(wdata)));
    assert_free_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op == OP_FREE) |=> (st_q.mem[$past(idx)] == '0));
    assert_peek_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!en || op == OP_PEEK) |=> (st_q.mem == $past(st_q.mem)));

endmodule

// File: rtl/lockunit_rsp.sv
module lockunit_rsp #(
    parameter int NPORT = 4,
    parameter int DW    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NPORT-1:0]    fire,
    input  logic [DW-1:0]       result,
    output logic [NPORT-1:0]    rsp_valid,
    output logic [NPORT*DW-1:0] rsp_data
);

    typedef struct packed {
        logic [NPORT-1:0]         vld;
        logic [NPORT-1:0][DW-1:0] dat;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = fire;
        for (int p = 0; p < NPORT; p++) begin
            if (fire[p]) st_d.dat[p] = result;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid = st_q.vld;

    generate
        for (genvar g = 0; g < NPORT; g++) begin : g_lane
            assign rsp_data[g*DW +: DW] = st_q.dat[g];
        end
    endgenerate

    // R9: at most one response strobe at a time
    assert_one_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rsp_valid));

endmodule

// File: rtl/lockunit_top.sv
module lockunit_top
    import lockunit_pkg::*;
#(
    parameter  int NPORT = 4,
    parameter  int NLOCK = 8,
    parameter  int DW    = 8,
    localparam int LW    = (NLOCK > 1) ? $clog2(NLOCK) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NPORT-1:0]    req_valid,
    output logic [NPORT-1:0]    req_ready,
    input  logic [2*NPORT-1:0]  req_op,
    input  logic [NPORT*LW-1:0] req_idx,
    input  logic [NPORT*DW-1:0] req_wdata,
    output logic [NPORT-1:0]    rsp_valid,
    output logic [NPORT*DW-1:0] rsp_data
);

    localparam int PW = (NPORT > 1) ? $clog2(NPORT) : 1;

    logic [NPORT-1:0] arb_req, gnt;
    logic [PW-1:0]    gnt_idx;
    logic             gnt_any;
    lk_op_e           sel_op;
    logic [LW-1:0]    sel_idx;
    logic [DW-1:0]    sel_wdata, result;

    assign arb_req   = req_valid & {NPORT{rst_n}};
    assign req_ready = gnt;

    lockunit_rr_arb #(.N(NPORT), .PW(PW)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (arb_req),
        .gnt     (gnt),
        .gnt_idx (gnt_idx),
        .gnt_any (gnt_any)
    );

    always_comb begin
        sel_op    = lk_op_e'(req_op[gnt_idx*2 +: 2]);
        sel_idx   = req_idx[gnt_idx*LW +: LW];
        sel_wdata = req_wdata[gnt_idx*DW +: DW];
    end

    lockunit_store #(.NLOCK(NLOCK), .DW(DW), .LW(LW)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (gnt_any),
        .op     (sel_op),
        .idx    (sel_idx),
        .wdata  (sel_wdata),
        .result (result)
    );

    lockunit_rsp #(.NPORT(NPORT), .DW(DW)) u_rsp (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (gnt),
        .result    (result),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data)
    );

    // R9: response follows the handshake by one cycle, on the same port
    assert_rsp_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|(req_valid & req_ready)) |=> (rsp_valid == $past(req_valid & req_ready)));
    assert_no_stray_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(req_valid & req_ready)) |=> (rsp_valid == '0));

endmodule

// File: tb/sim_lockunit_top.sv
`timescale 1ns/1ps
module sim_lockunit_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  v = '0;
    logic [7:0]  opv = '0;
    logic [11:0] idxv = '0;
    logic [31:0] wdv = '0;
    logic [3:0]  ready, rsp_valid;
    logic [31:0] rsp_data;

    always #2.5 clk = ~clk;

    lockunit_top u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (v),
        .req_ready (ready),
        .req_op    (opv),
        .req_idx   (idxv),
        .req_wdata (wdv),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data)
    );

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int rr_next = 0;
    logic [7:0] model_mem [8];
    int q_port [$];
    int q_due [$];
    logic [7:0] q_dat [$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic logic [7:0] apply(input int op, input int idx, input logic [7:0] wd);
        logic [7:0] old;
        old = model_mem[idx];
        case (op)
            0: begin
                if (old == 8'd0) begin model_mem[idx] = 8'd1; return 8'd1; end
                return 8'd0;
            end
            1: begin model_mem[idx] = wd; return old; end
            2: begin model_mem[idx] = 8'd0; return old; end
            default: return old;
        endcase
    endfunction

    function automatic int next_winner();
        for (int off = 0; off < 4; off++) begin
            if (v[(rr_next + off) % 4]) return (rr_next + off) % 4;
        end
        return -1;
    endfunction

    task automatic post(input int p, input int op, input int idx, input logic [7:0] wd);
        v[p] = 1'b1;
        opv[p*2 +: 2] = 2'(op);
        idxv[p*3 +: 3] = 3'(idx);
        wdv[p*8 +: 8] = wd;
    endtask

    // Called just after a falling edge; returns after the next falling edge.
    task automatic tick(input int want);
        int g;
        logic [3:0] fire;
        g = -1;
        #1;
        fire = v & ready;
        chk(((ready & ~v) == 4'd0) && ($countones(ready) <= 1), "R7", ready, v);
        if (want >= 0) chk(ready == 4'(1 << want), "R8", ready, 1 << want);
        for (int p = 0; p < 4; p++) if (fire[p]) g = p;
        if (g >= 0) begin
            q_port.push_back(g);
            q_due.push_back(cyc + 1);
            q_dat.push_back(apply(int'(opv[g*2 +: 2]), int'(idxv[g*3 +: 3]), wdv[g*8 +: 8]));
            rr_next = (g + 1) % 4;
        end
        @(posedge clk);
        #1;
        if (g >= 0) v[g] = 1'b0;
        @(negedge clk);
    endtask

    task automatic drain();
        while (v != 4'd0) tick(next_winner());
        tick(-1);
    endtask

    task automatic single(input int p, input int op, input int idx, input logic [7:0] wd);
        post(p, op, idx, wd);
        drain();
    endtask

    // Scoreboard monitor (R9 timing, data for R1..R6, R10)
    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            for (int p = 0; p < 4; p++) begin
                if (rsp_valid[p]) begin
                    if (q_port.size() == 0) begin
                        chk(1'b0, "R9 unexpected response", p, -1);
                    end else begin
                        chk(q_port[0] == p && q_due[0] == cyc, "R9", p, q_port[0]);
                        chk(rsp_data[p*8 +: 8] == q_dat[0], "R2-6,R10 data", rsp_data[p*8 +: 8], q_dat[0]);
                        void'(q_port.pop_front());
                        void'(q_due.pop_front());
                        void'(q_dat.pop_front());
                    end
                end
            end
            if (q_due.size() > 0 && q_due[0] < cyc && rsp_valid == 4'd0)
                chk(1'b0, "R9 missing response", 0, 1);
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R9 actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) model_mem[i] = 8'd0;
        repeat (3) @(posedge clk);
        #1;
        chk(rsp_valid == 4'd0 && ready == 4'd0, "R1 reset outputs", rsp_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1, R6: every word reads 0 after reset
        for (int i = 0; i < 8; i++) single(i % 4, 3, i, 8'h00);

        // R2: take a free word; R3: second take fails, word unchanged
        single(0, 0, 2, 8'h00);
        single(1, 0, 2, 8'h00);
        single(3, 3, 2, 8'h00);

        // R4: exchange returns previous contents
        single(2, 1, 5, 8'hA5);
        single(3, 1, 5, 8'h3C);
        single(0, 3, 5, 8'h00);

        // R3: non-one, non-zero value is held and unchanged
        single(1, 0, 5, 8'h00);
        single(2, 3, 5, 8'h00);

        // R5: release clears and returns the old value; retake succeeds
        single(1, 2, 2, 8'h00);
        single(0, 3, 2, 8'h00);
        single(3, 0, 2, 8'h00);

        // R10, R8: four ports race for free word 7 in one cycle
        for (int p = 0; p < 4; p++) post(p, 0, 7, 8'h00);
        drain();
        single(1, 3, 7, 8'h00);

        // R8: port 2 alone, then all four: order must start at port 3
        single(2, 3, 0, 8'h00);
        for (int p = 0; p < 4; p++) post(p, 3, p, 8'h00);
        tick(3);
        tick(0);
        tick(1);
        tick(2);
        tick(-1);

        // R4 on several ports against different words in one burst
        post(0, 1, 1, 8'h11);
        post(1, 1, 3, 8'h33);
        post(2, 1, 1, 8'h77);
        post(3, 2, 3, 8'h00);
        drain();
        single(0, 3, 1, 8'h00);
        single(2, 3, 3, 8'h00);

        repeat (3) @(negedge clk);
        chk(q_port.size() == 0, "R9 all responses seen", q_port.size(), 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule